// File: doc/BRIEF.md
# Synchronized Multi-Output Clock Gate

This block takes one reference clock and fans it out to six clock outputs. One output is a free-running copy of the reference. The other five form a gated group that starts and stops together under a single enable input. That enable may change at any time with no fixed relation to the clock.

The enable is brought into the clock domain through a chain of rising-edge flops. A last gating flop is clocked on the falling edge and sits in front of an AND gate. This flop only changes while the reference is low. As a result, a gated output only ever produces whole high and low phases when it starts or stops. A stopped output rests at logic low.

The reset is synchronous and active high. It clears the synchronizer and the gating flops. The free-running output keeps toggling while reset is held.

Top module: `clk_fanout_gate`

## Requirements
- R1: `clk_always` follows the reference clock on every edge, whatever the levels of `en_async` and `rst`.
- R2: The five bits of `clk_gated` carry identical values at all times once the first falling edge under reset has passed.
- R3: No high or low phase on any `clk_gated` bit is shorter than half a reference period. The gating state changes only while the reference clock is low.
- R4: After `en_async` rises, the first rising edge on `clk_gated` comes at the third rising reference edge that follows the change. This is within four cycles.
- R5: After `en_async` falls, `clk_gated` is low from the third rising reference edge that follows the change, and it stays low. This is within four cycles.
- R6: While the group is running, each `clk_gated` bit equals the reference clock in both its high and low phases, with no inversion and no division.
- R7: While `rst` is high on rising edges, the synchronizer clears and `clk_gated` is held at 0 from the first falling edge onward. After release, the group stays low until the enable has passed the synchronizer.
- R8: If an enable pulse is high across exactly one rising reference edge, the group gives exactly one full clock pulse. If an enable pulse is high between two rising edges without covering either, the group gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| en_async | input | 1 | Group enable, asynchronous to `clk_ref` |
| clk_always | output | 1 | Free-running copy of the reference |
| clk_gated | output | 5 | Gated clock group, low when stopped |

## Verification
If a synchronizer stage is stuck or lost, start and stop latency moves off three rising edges. This shows on `clk_gated` within four cycles of any enable change. If the gating flop is moved to the rising edge, or its reset is dropped, the result is a half-width phase, or an X or high level, during the first gated cycle. The bench times every phase edge, so that cycle is flagged.

If one gated bit is miswired, it disagrees with its neighbours at the next mid-high sample. Short enable pulses show whether the synchronizer samples on exactly one edge: the bench counts whole pulses within eight cycles.

// File: rtl/cg_pkg.sv
package cg_pkg;

    // Number of gated outputs in the group.
    localparam int unsigned NUM_GATED   = 5;
    // Rising-edge stages in front of the falling-edge gating flop.
    localparam int unsigned SYNC_STAGES = 2;
    // Saturation value of the post-reset settle counter in the checker logic.
    localparam int unsigned SETTLE_MAX  = 3;
    localparam int unsigned SETTLE_W    = $clog2(SETTLE_MAX + 1);

    typedef logic [NUM_GATED-1:0] gate_vec_t;

    // Enable state as carried from the synchronizer to the gate cells.
    typedef struct packed {
        logic synced;   // last rising-edge stage
        logic first;    // first rising-edge stage
    } en_sync_t;

    // True when the group is uniformly running or uniformly stopped.
    function automatic logic group_uniform(input gate_vec_t v);
        return (v == '0) || (v == '1);
    endfunction

endpackage

// File: rtl/cg_en_sync.sv
module cg_en_sync
    import cg_pkg::*;
#(
    parameter int unsigned STAGES = SYNC_STAGES
) (
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     en_i,
    output en_sync_t state_o
);

    logic [STAGES-1:0] chain_q;

    generate
        genvar s;
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_head
                always_ff @(posedge clk_i) begin
                    if (rst_i) chain_q[0] <= 1'b0;
                    else       chain_q[0] <= en_i;
                end
            end else begin : g_tail
                always_ff @(posedge clk_i) begin
                    if (rst_i) chain_q[s] <= 1'b0;
                    else       chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign state_o.synced = chain_q[STAGES-1];
    assign state_o.first  = chain_q[0];

endmodule

// File: rtl/cg_gate_cell.sv
module cg_gate_cell (
    input  logic clk_i,
    input  logic rst_i,
    input  logic run_i,
    output logic gate_o,
    output logic clk_o
);

    logic gate_q;

    // Falling-edge flop: the gate moves only while the clock is low.
    always_ff @(negedge clk_i) begin
        if (rst_i) gate_q <= 1'b0;
        else       gate_q <= run_i;
    end

    assign gate_o = gate_q;
    assign clk_o  = clk_i & gate_q;

    always @(gate_q) begin
        if (!rst_i && !$isunknown(gate_q)) begin
            AST_GATE_MOVES_LOW: assert (clk_i == 1'b0) else $error("gate changed while clock high"); // R3
        end
    end

endmodule

// File: rtl/clk_fanout_gate.sv
module clk_fanout_gate
    import cg_pkg::*;
(
    input  logic                 clk_ref,
    input  logic                 rst,
    input  logic                 en_async,
    output logic                 clk_always,
    output logic [NUM_GATED-1:0] clk_gated
);

    en_sync_t  sync_st;
    gate_vec_t gate_st;

    assign clk_always = clk_ref;

    cg_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_ref),
        .rst_i   (rst),
        .en_i    (en_async),
        .state_o (sync_st)
    );

    generate
        genvar g;
        for (g = 0; g < NUM_GATED; g++) begin : g_cell
            cg_gate_cell u_cell (
                .clk_i  (clk_ref),
                .rst_i  (rst),
                .run_i  (sync_st.synced),
                .gate_o (gate_st[g]),
                .clk_o  (clk_gated[g])
            );
        end
    endgenerate

    // Cycles since reset release, saturating; qualifies history-based checks.
    logic [SETTLE_W-1:0] settle_q;
    always_ff @(posedge clk_ref) begin
        if (rst)                                 settle_q <= '0;
        else if (settle_q != SETTLE_W'(SETTLE_MAX)) settle_q <= settle_q + 1'b1;
    end

    AST_START_LATENCY: assert property (@(posedge clk_ref) disable iff (rst)
        ((settle_q == SETTLE_W'(SETTLE_MAX)) && $past(en_async, 2)) |-> (gate_st == '1)) else $error("start latency"); // R4
    AST_STOP_LATENCY: assert property (@(posedge clk_ref) disable iff (rst)
        ((settle_q == SETTLE_W'(SETTLE_MAX)) && !$past(en_async, 2)) |-> (gate_st == '0)) else $error("stop latency"); // R5
    AST_GROUP_UNIFORM: assert property (@(negedge clk_ref) disable iff (rst)
        (settle_q != '0) |-> group_uniform(clk_gated)) else $error("group split"); // R2

endmodule

// File: tb/clk_fanout_gate_test.sv
`timescale 1ns/1ps
module clk_fanout_gate_test;
    import cg_pkg::*;

    localparam real PERIOD = 4.0;
    localparam real HALF   = PERIOD / 2.0;
    localparam int  NVEC   = 8;

    // {enable level, offset after rising edge in 0.1 ns, cycles to hold}
    typedef struct packed { logic en; logic [7:0] off; logic [7:0] hold; } vec_t;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 8'd5,  8'd6},
        '{1'b0, 8'd12, 8'd5},
        '{1'b1, 8'd25, 8'd4},
        '{1'b0, 8'd35, 8'd7},
        '{1'b1, 8'd18, 8'd3},
        '{1'b0, 8'd7,  8'd3},
        '{1'b1, 8'd31, 8'd9},
        '{1'b0, 8'd22, 8'd6}
    };

    logic clk_ref = 1'b0;
    logic rst = 1'b1;
    logic en_async = 1'b0;
    logic clk_always;
    logic [NUM_GATED-1:0] clk_gated;

    int checks = 0;
    int failures = 0;
    int phase_bad = 0;
    int phase_edges = 0;
    bit done = 0;

    clk_fanout_gate uut (
        .clk_ref(clk_ref), .rst(rst), .en_async(en_async),
        .clk_always(clk_always), .clk_gated(clk_gated)
    );

    always #(HALF) clk_ref = ~clk_ref;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // R3 phase monitor on every gated bit
    real last_t [NUM_GATED];
    logic [NUM_GATED-1:0] prev_g = '0;
    bit mon_on = 0;
    always @(clk_gated) begin
        for (int i = 0; i < NUM_GATED; i++) begin
            if (mon_on && !$isunknown(clk_gated[i]) && clk_gated[i] != prev_g[i]) begin
                phase_edges++;
                if ($realtime - last_t[i] < HALF - 0.05) begin
                    phase_bad++;
                    $display("FAIL R3 bit %0d phase actual=%0f expected>=%0f", i, $realtime - last_t[i], HALF);
                end
                last_t[i] = $realtime;
            end
        end
        prev_g = clk_gated;
    end

    // R1 toggle counter
    int always_toggles = 0;
    always @(clk_always) always_toggles++;

    task automatic after_rise;
        @(posedge clk_ref); #(0.5);
    endtask

    initial begin : watchdog
        #(PERIOD * 200000.0);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        int n;
        int pulses;
        // ---- reset phase (R7, R1)
        repeat (2) @(posedge clk_ref);
        #(0.5);
        check(clk_gated == '0, "R7 gated low in reset", int'(clk_gated), 0);
        en_async = 1'b1;
        always_toggles = 0;
        repeat (6) after_rise;
        check(clk_gated == '0, "R7 enable ignored in reset", int'(clk_gated), 0);
        check(always_toggles == 12, "R1 runs in reset", always_toggles, 12);
        en_async = 1'b0;
        for (int i = 0; i < NUM_GATED; i++) last_t[i] = $realtime;
        prev_g = clk_gated;
        mon_on = 1;
        rst = 1'b0;
        repeat (5) begin
            after_rise;
            check(clk_gated == '0, "R7 low after release", int'(clk_gated), 0);
        end

        // ---- vector table (R4, R5, R6, R2, R1)
        for (int v = 0; v < NVEC; v++) begin
            @(posedge clk_ref);
            #(real'(VECS[v].off) / 10.0);
            en_async = VECS[v].en;
            n = 0;
            do begin
                after_rise;
                n++;
            end while ((clk_gated != (VECS[v].en ? '1 : '0)) && n < 8);
            if (VECS[v].en) check(n == 3, "R4 start latency", n, 3);
            else            check(n == 3, "R5 stop latency", n, 3);
            for (int c = 0; c < VECS[v].hold; c++) begin
                check(clk_gated == (VECS[v].en ? '1 : '0), "R6 high phase", int'(clk_gated), VECS[v].en ? 31 : 0);
                check(clk_always == 1'b1, "R1 high", int'(clk_always), 1);
                @(negedge clk_ref); #(0.5);
                check(clk_gated == '0, "R6 low phase", int'(clk_gated), 0);
                check(clk_always == 1'b0, "R1 low", int'(clk_always), 0);
                check(group_uniform(clk_gated), "R2 uniform", int'(clk_gated), 0);
                after_rise;
            end
        end

        // ---- short pulse between edges (R8): no pulse
        en_async = 1'b0;
        repeat (5) @(posedge clk_ref);
        #(1.0); en_async = 1'b1; #(1.5); en_async = 1'b0;
        pulses = 0;
        repeat (8) begin after_rise; if (clk_gated[0]) pulses++; end
        check(pulses == 0, "R8 unsampled pulse", pulses, 0);

        // ---- short pulse over one edge (R8): exactly one full pulse
        @(posedge clk_ref);
        #(3.0); en_async = 1'b1; #(2.0); en_async = 1'b0;
        pulses = 0;
        repeat (8) begin after_rise; if (clk_gated == '1) pulses++; end
        check(pulses == 1, "R8 one sampled pulse", pulses, 1);
        check(clk_gated == '0, "R8 ends low", int'(clk_gated), 0);

        // ---- reset while running (R7, R1)
        en_async = 1'b1;
        repeat (6) after_rise;
        check(clk_gated == '1, "R7 running before reset", int'(clk_gated), 31);
        rst = 1'b1;
        @(negedge clk_ref); #(0.5);
        after_rise;
        check(clk_gated == '0, "R7 held low by reset", int'(clk_gated), 0);
        always_toggles = 0;
        repeat (4) after_rise;
        check(always_toggles == 8, "R1 toggles under reset", always_toggles, 8);
        rst = 1'b0;
        en_async = 1'b0;
        repeat (4) after_rise;

        check(phase_bad == 0 && phase_edges > 20, "R3 phase widths", phase_bad, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures + phase_bad);
        $finish;
    end

endmodule